// File: doc/BRIEF.md
# Two-Wire Memory Slave Write Front End

This block sits behind the SCL and SDA pads of a small byte-addressed serial memory. It listens to the two-wire bus with an oversampling system clock and recognises bus START and STOP conditions. After a START it shifts in a control byte and compares that byte's fixed device code. On a write it captures the word address and then any number of data bytes. It acknowledges every accepted byte by pulling SDA low for the ninth clock.

A downstream write engine consumes the block's results. That engine receives a one-cycle strobe with the word address, a one-cycle strobe with each data byte in arrival order, and a one-cycle programming-start pulse when the transaction ends with a STOP. While that engine is programming, it raises `busy`. The block then stays silent on the bus: it gives no acknowledge and no strobe until the next START arrives with `busy` low.

The controller has four states:
- `ST_IDLE` waits for a START.
- `ST_CTRL` receives the control byte.
- `ST_WADDR` receives the word address.
- `ST_DATA` receives data bytes.

Its transitions are:
- Any state goes to `ST_CTRL` on START.
- Any state goes to `ST_IDLE` on STOP.
- `ST_CTRL` goes to `ST_WADDR` on a matching write control byte. It goes to `ST_IDLE` on a mismatch, on a read, or while busy.
- `ST_WADDR` goes to `ST_DATA` on the address byte, or to `ST_IDLE` if busy.
- `ST_DATA` stays in `ST_DATA` per data byte, or goes to `ST_IDLE` if busy.

Top module: `twi_mem_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point, including in the middle of a byte, restarts control-byte reception from its first bit.
- R2: The control byte matches when its bits [7:4] equal 4'b1010. Bits [3:1] are ignored for matching.
- R3: Control-byte bit 0 selects the direction, with 0 for write and 1 for read. A matching read control byte is acknowledged, and the block then goes idle and produces no strobes until the next START.
- R4: The slave drives `sda_pull_low` high for an accepted byte from the SCL falling edge after the eighth data bit to the falling edge of the ninth clock. It never drives it during the eight data bits.
- R5: While `busy` is high when a byte completes, that byte gets no acknowledge and no strobe, and the block goes idle until the next START.
- R6: In a write, the first byte after the control byte produces exactly one `waddr_strobe` pulse, with the byte on `waddr`.
- R7: Every following byte of the write produces one `wdata_strobe` pulse, with the byte on `wdata`, in bus order.
- R8: A STOP after at least one accepted data byte produces exactly one `prog_start` pulse. A STOP after only the address produces none.
- R9: After a non-matching control byte, all later bytes up to the next START get no acknowledge and no strobe.
- R10: After reset, `sda_pull_low`, `waddr_strobe`, `wdata_strobe` and `prog_start` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| busy | input | 1 | Internal programming cycle running; suppresses acknowledges |
| sda_pull_low | output | 1 | Drive SDA low (acknowledge) |
| waddr_strobe | output | 1 | One-cycle word-address valid |
| waddr | output | 8 | Captured word address |
| wdata_strobe | output | 1 | One-cycle data-byte valid |
| wdata | output | 8 | Captured data byte |
| prog_start | output | 1 | One-cycle pulse: start internal write cycle |

## Verification
The hardest case to reach from the ports is a repeated START that cuts into a partly shifted control byte. It must wipe the bit counter without leaving a stale acknowledge or strobe. The bench drives three bits, raises SDA while SCL is low, and forms a fresh START. It then sends a complete write and expects the acknowledges and strobes of that write alone. A second hard case is `busy` rising between an acknowledged control byte and the address byte. The bench raises it just after the control byte's ninth clock, so the address is refused in the middle of the transaction.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WADDR,
        ST_DATA
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_prev, sda_prev;
    logic scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

    assert_start_stop_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
    assert_no_cond_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise || scl_fall) |-> !(start_det || stop_det));
endmodule

// File: rtl/twi_byte_shift.sv
module twi_byte_shift #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_reset,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [BYTE_W-1:0] byte_val,
    output logic              byte_ready
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            byte_val   <= '0;
            byte_ready <= 1'b0;
        end else begin
            byte_ready <= 1'b0;
            if (frame_reset) begin
                bit_cnt <= '0;
            end else if (scl_rise) begin
                if (bit_cnt < ACK_SLOT) begin
                    byte_val <= {byte_val[BYTE_W-2:0], sda_lvl};
                end
                if (bit_cnt == LAST_BIT) begin
                    byte_ready <= 1'b1;
                end
                if (bit_cnt < ACK_DONE) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (scl_fall && bit_cnt == ACK_DONE) begin
                bit_cnt <= '0;
            end
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= ACK_DONE);
    assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_reset |=> (bit_cnt == '0));
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import twi_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_fall,
    input  logic              byte_ready,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              busy,
    output logic              sda_low,
    output logic              addr_valid,
    output logic [BYTE_W-1:0] addr_byte,
    output logic              data_valid,
    output logic [BYTE_W-1:0] data_byte,
    output logic              wr_go
);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

    twi_state_e state, state_nx;
    logic ack_req;
    logic data_seen;
    logic ctrl_hit;

    assign ctrl_hit = (byte_val[BYTE_W-1 -: 4] == DEV_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_CTRL;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (byte_ready) begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_CTRL:  state_nx = (ctrl_hit && !busy && !byte_val[0]) ? ST_WADDR : ST_IDLE;
                ST_WADDR: state_nx = busy ? ST_IDLE : ST_DATA;
                ST_DATA:  state_nx = busy ? ST_IDLE : ST_DATA;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_req    <= 1'b0;
            sda_low    <= 1'b0;
            addr_valid <= 1'b0;
            addr_byte  <= '0;
            data_valid <= 1'b0;
            data_byte  <= '0;
            wr_go      <= 1'b0;
            data_seen  <= 1'b0;
        end else begin
            addr_valid <= 1'b0;
            data_valid <= 1'b0;
            wr_go      <= 1'b0;
            if (start_det || stop_det) begin
                ack_req   <= 1'b0;
                sda_low   <= 1'b0;
                data_seen <= 1'b0;
                if (stop_det && state == ST_DATA && data_seen) begin
                    wr_go <= 1'b1;
                end
            end else begin
                if (byte_ready) begin
                    unique case (state)
                        ST_IDLE: ack_req <= 1'b0;
                        ST_CTRL: ack_req <= ctrl_hit && !busy;
                        ST_WADDR: begin
                            ack_req <= !busy;
                            if (!busy) begin
                                addr_valid <= 1'b1;
                                addr_byte  <= byte_val;
                            end
                        end
                        ST_DATA: begin
                            ack_req <= !busy;
                            if (!busy) begin
                                data_valid <= 1'b1;
                                data_byte  <= byte_val;
                                data_seen  <= 1'b1;
                            end
                        end
                        default: ack_req <= 1'b0;
                    endcase
                end
                if (scl_fall && bit_cnt == ACK_SLOT) begin
                    sda_low <= ack_req;
                end else if (scl_fall && bit_cnt == ACK_DONE) begin
                    sda_low <= 1'b0;
                    ack_req <= 1'b0;
                end
            end
        end
    end

    assert_ack_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low |-> (bit_cnt == ACK_SLOT || bit_cnt == ACK_DONE));
    assert_addr_from_waddr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ($past(state) == ST_WADDR));
    assert_data_from_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> ($past(state) == ST_DATA));
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({addr_valid, data_valid, wr_go}) <= 1);
    assert_go_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (state == ST_IDLE));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              busy,
    output logic              sda_pull_low,
    output logic              waddr_strobe,
    output logic [BYTE_W-1:0] waddr,
    output logic              wdata_strobe,
    output logic [BYTE_W-1:0] wdata,
    output logic              prog_start
);
    localparam int CNT_W = $clog2(BYTE_W + 2);

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] byte_val;
    logic byte_ready;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_reset (start_det | stop_det),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .sda_lvl     (sda_lvl),
        .bit_cnt     (bit_cnt),
        .byte_val    (byte_val),
        .byte_ready  (byte_ready)
    );

    twi_slave_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .scl_fall   (scl_fall),
        .byte_ready (byte_ready),
        .byte_val   (byte_val),
        .bit_cnt    (bit_cnt),
        .busy       (busy),
        .sda_low    (sda_pull_low),
        .addr_valid (waddr_strobe),
        .addr_byte  (waddr),
        .data_valid (wdata_strobe),
        .data_byte  (wdata),
        .wr_go      (prog_start)
    );
endmodule

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_pull_low, waddr_strobe, wdata_strobe, prog_start;
    logic [7:0] waddr, wdata;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    int n_addr = 0, n_data = 0, n_go = 0;
    logic [7:0] last_addr = '0;
    logic [7:0] data_log [0:7];
    bit done = 1'b0;

    always #4 clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull_low;

    twi_mem_slave i_twi_mem_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .busy         (busy),
        .sda_pull_low (sda_pull_low),
        .waddr_strobe (waddr_strobe),
        .waddr        (waddr),
        .wdata_strobe (wdata_strobe),
        .wdata        (wdata),
        .prog_start   (prog_start)
    );

    always @(negedge clk) begin
        if (waddr_strobe) begin
            n_addr    <= n_addr + 1;
            last_addr <= waddr;
        end
        if (wdata_strobe) begin
            if (n_data < 8) data_log[n_data] <= wdata;
            n_data <= n_data + 1;
        end
        if (prog_start) n_go <= n_go + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic clear_log();
        @(negedge clk);
        n_addr = 0;
        n_data = 0;
        n_go   = 0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half();
        scl = 1'b1;   half();
        sda_m = 1'b0; half();
        scl = 1'b0;   half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl = 1'b1;   half();
        sda_m = 1'b1; half();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic early);
        early = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; half();
            scl = 1'b1;   half();
            if (sda_pull_low) early = 1'b1;
            scl = 1'b0;   half();
        end
        sda_m = 1'b1; half();
        scl = 1'b1;
        repeat (H / 2) @(negedge clk);
        acked = sda_pull_low;
        repeat (H - H / 2) @(negedge clk);
        scl = 1'b0;
        half();
        if (sda_pull_low) early = 1'b1;
    endtask

    // ctrl[20:13] addr[12:5] ndata[4:2] busy_at[1:0] (0 never, 1 from start, 2 after control byte)
    localparam logic [20:0] VEC [0:7] = '{
        {8'hA0, 8'h10, 3'd1, 2'd0},
        {8'hAE, 8'h27, 3'd4, 2'd0},
        {8'hA5, 8'h33, 3'd2, 2'd0},
        {8'hB0, 8'h44, 3'd2, 2'd0},
        {8'hA0, 8'h55, 3'd2, 2'd1},
        {8'hA0, 8'h66, 3'd0, 2'd0},
        {8'h2A, 8'h77, 3'd1, 2'd0},
        {8'hA2, 8'h88, 3'd3, 2'd2}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack, early, any_early, all_dack;
        repeat (5) @(negedge clk);
        // R10: reset state
        chk("R10 pull_low", sda_pull_low, 0);
        chk("R10 waddr_strobe", waddr_strobe, 0);
        chk("R10 wdata_strobe", wdata_strobe, 0);
        chk("R10 prog_start", prog_start, 0);
        rst_n = 1'b1;
        half();

        for (int v = 0; v < 8; v++) begin
            logic [7:0] c, a;
            int nd, ba;
            logic match, ok_ctrl, is_wr, addr_ok;
            c  = VEC[v][20:13];
            a  = VEC[v][12:5];
            nd = int'(VEC[v][4:2]);
            ba = int'(VEC[v][1:0]);
            match   = (c[7:4] == 4'b1010);          // R2
            ok_ctrl = match && (ba != 1);           // R5
            is_wr   = ok_ctrl && !c[0];             // R3
            addr_ok = is_wr && (ba != 2);           // R5 R6
            clear_log();
            busy = (ba == 1);
            any_early = 1'b0;
            all_dack = 1'b1;
            bus_start();
            send_byte(c, ack, early);
            any_early |= early;
            chk($sformatf("R2 R3 R9 ctrl ack v%0d", v), ack, ok_ctrl);
            if (ba == 2) busy = 1'b1;
            send_byte(a, ack, early);
            any_early |= early;
            chk($sformatf("R5 R6 addr ack v%0d", v), ack, addr_ok);
            for (int k = 0; k < nd; k++) begin
                send_byte(a + 8'(8'h11 * (k + 1)), ack, early);
                any_early |= early;
                if (ack !== addr_ok) all_dack = 1'b0;
            end
            chk($sformatf("R7 R9 data acks v%0d", v), all_dack, 1);
            bus_stop();
            half();
            busy = 1'b0;
            chk($sformatf("R4 no early ack v%0d", v), any_early, 0);
            chk($sformatf("R6 addr count v%0d", v), n_addr, addr_ok ? 1 : 0);
            if (addr_ok) chk($sformatf("R6 addr value v%0d", v), last_addr, a);
            chk($sformatf("R7 data count v%0d", v), n_data, addr_ok ? nd : 0);
            if (addr_ok) begin
                for (int k = 0; k < nd; k++)
                    chk($sformatf("R7 data[%0d] v%0d", k, v), data_log[k], a + 8'(8'h11 * (k + 1)));
            end
            chk($sformatf("R8 prog_start v%0d", v), n_go, (addr_ok && nd > 0) ? 1 : 0);
        end

        // R1: repeated START after three bits of a control byte
        clear_log();
        bus_start();
        for (int i = 7; i >= 5; i--) begin
            sda_m = VEC[0][13 + i]; half();
            scl = 1'b1; half();
            scl = 1'b0; half();
        end
        bus_start();
        send_byte(8'hA0, ack, early);
        chk("R1 ctrl ack after restart", ack, 1);
        send_byte(8'h5A, ack, early);
        chk("R1 addr ack after restart", ack, 1);
        send_byte(8'hC3, ack, early);
        chk("R1 data ack after restart", ack, 1);
        bus_stop();
        half();
        chk("R1 addr after restart", last_addr, 8'h5A);
        chk("R1 addr count after restart", n_addr, 1);
        chk("R1 data after restart", data_log[0], 8'hC3);
        chk("R8 go after restart", n_go, 1);

        // R4: the acknowledge is released after the ninth clock
        clear_log();
        bus_start();
        send_byte(8'hA0, ack, early);
        chk("R4 released after ninth clock", sda_pull_low, 0);
        chk("R4 ack held in ninth clock", ack, 1);
        bus_stop();
        half();
        chk("R8 no go without data", n_go, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule